// File: doc/BRIEF.md
# Highway and Side-Road Intersection Light Controller

This block sequences the signal lamps at a junction where a heavily used highway meets a side road that sees little traffic. The highway keeps its green by default. It gives up the right of way only when a vehicle sensor on the side road reports a car and the highway has already been green for a guaranteed minimum interval. The highway then passes through amber to red. The side road is green for as long as cars keep arriving, up to a cap. Then the side road passes through amber and the highway takes the green again.

All timing comes from one restartable interval timer. The controller strobes the timer on every phase change. The timer raises a short-interval flag that sets the amber phases and a long-interval flag that sets the green phases. Each flag stays up until the next strobe. A parameter selects the state register implementation: a dense binary code or a one-hot code. The lamps behave the same in both cases. Intervals are parameters counted in clock cycles, with the long interval greater than the short one and both at least one cycle.

Top module: `xroad_light_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the controller enters highway-green. From the following cycle the highway shows green (00) and the side road shows red (10). A reset asserted at any point in the sequence returns the lamps to this state.
- R2: Each lamp output is a 2-bit code: 00 green, 01 amber, 10 red. The code 11 never appears. In every cycle at least one road shows red.
- R3: Highway green lasts at least LONG_CYC+1 cycles. Suppose the car sensor is first high at or after green cycle LONG_CYC, in cycle a (counted from 0 at green entry). Then highway green lasts max(a, LONG_CYC)+1 cycles. If the sensor stays high, green lasts exactly LONG_CYC+1 cycles.
- R4: Highway amber lasts exactly SHORT_CYC+1 cycles. It is followed by side-road green with the highway at red.
- R5: Side-road green ends after the first of its cycles in which the sensor is low, or after cycle LONG_CYC, whichever comes first. With the sensor first low in side-green cycle d, side green lasts min(d, LONG_CYC)+1 cycles and never more than LONG_CYC+1.
- R6: Side-road amber lasts exactly SHORT_CYC+1 cycles. It is followed by highway green with the side road at red.
- R7: The phases always run highway-green, highway-amber, side-green, side-amber, then back to highway-green. A road showing amber never shows green in the next cycle.
- R8: With ONE_HOT set to 1 or 0, the two lamp outputs are identical cycle for cycle under the same inputs.
- R9: A car pulse on the sensor that ends before the long interval has expired in highway green has no effect. The highway stays green until the sensor is high in a cycle where the long interval has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| car_present | input | 1 | Side-road vehicle sensor, high while a car waits |
| hwy_light | output | 2 | Highway lamp code (00 green, 01 amber, 10 red) |
| side_light | output | 2 | Side-road lamp code (00 green, 01 amber, 10 red) |

## Verification
The bound checker watches the safety properties on every cycle. These are that no lamp code is illegal, that at least one road is red, that no amber turns straight to green, and that the timer flag drops after each restart. Run-length counters in the checker also enforce the highway green minimum and the side-road green cap on every cycle. The exact length of each phase as a function of when the car arrives and leaves can only be shown by the bench's sweep over arrival and departure cycles. The same holds for the sensor pulse being ignored, for reset in mid-sequence, and for cycle-by-cycle agreement between the two state encodings.

// File: rtl/xroad_pkg.sv
// Shared types for the intersection light controller.
// Assumes: lamp codes are fixed by the outward interface; phase codes are internal.
package xroad_pkg;

    // Lamp codes seen on the output pins
    typedef enum logic [1:0] {
        LAMP_GO   = 2'b00,
        LAMP_WARN = 2'b01,
        LAMP_STOP = 2'b10
    } lamp_t;

    // Controller phases (dense binary code, Gray order around the loop)
    typedef enum logic [1:0] {
        PH_HWY_GO    = 2'b00,
        PH_HWY_WARN  = 2'b01,
        PH_SIDE_GO   = 2'b11,
        PH_SIDE_WARN = 2'b10
    } phase_t;

    // Bit positions inside the one-hot phase register
    localparam int OH_HWY_GO    = 0;
    localparam int OH_HWY_WARN  = 1;
    localparam int OH_SIDE_GO   = 2;
    localparam int OH_SIDE_WARN = 3;
    localparam int OH_W         = 4;

endpackage

// File: rtl/xroad_interval_timer.sv
// Restartable interval timer.
// Counts clock cycles since the last restart strobe and saturates at the long
// interval. Flags are raised at expiry and held until the next restart.
// Assumes: 1 <= SHORT_CYC < LONG_CYC. Reset acts as a restart.
module xroad_interval_timer #(
    parameter int SHORT_CYC = 2,
    parameter int LONG_CYC  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic short_done,
    output logic long_done
);
    localparam int CNT_W = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);

    logic [CNT_W-1:0] elapsed_q;

    // Cycle counter: cleared by restart or reset, saturating at the long limit
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            elapsed_q <= '0;
        end else if (elapsed_q != LONG_V) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    // Expiry flags: held because the counter saturates above both limits
    always_comb begin
        short_done = (elapsed_q >= SHORT_V);
        long_done  = (elapsed_q == LONG_V);
    end

endmodule

// File: rtl/xroad_phase_fsm.sv
// Four-phase intersection sequencer.
// Produces the current phase and a one-cycle timer restart strobe on each
// phase change. ONE_HOT picks the state register: 0 = 2-bit binary,
// 1 = 4-bit one-hot with per-bit next-state equations.
// Assumes: timer flags come from xroad_interval_timer restarted by `restart`.
module xroad_phase_fsm
    import xroad_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   car,
    input  logic   short_done,
    input  logic   long_done,
    output phase_t phase,
    output logic   restart
);
    // Transition conditions shared by both encodings
    logic leave_hwy_go;
    logic leave_side_go;

    // Exit conditions for the two green phases
    always_comb begin
        leave_hwy_go  = car && long_done;
        leave_side_go = !car || long_done;
    end

    generate
        if (ONE_HOT) begin : g_onehot
            logic [OH_W-1:0] hot_q;
            logic [OH_W-1:0] hot_d;

            // Per-bit next-state equations of the one-hot register
            always_comb begin
                hot_d[OH_HWY_GO]    = (hot_q[OH_HWY_GO] && !leave_hwy_go)
                                    || (hot_q[OH_SIDE_WARN] && short_done);
                hot_d[OH_HWY_WARN]  = (hot_q[OH_HWY_GO] && leave_hwy_go)
                                    || (hot_q[OH_HWY_WARN] && !short_done);
                hot_d[OH_SIDE_GO]   = (hot_q[OH_HWY_WARN] && short_done)
                                    || (hot_q[OH_SIDE_GO] && !leave_side_go);
                hot_d[OH_SIDE_WARN] = (hot_q[OH_SIDE_GO] && leave_side_go)
                                    || (hot_q[OH_SIDE_WARN] && !short_done);
            end

            // Restart strobe whenever any hot bit hands over
            always_comb begin
                restart = (hot_q[OH_HWY_GO]    && leave_hwy_go)
                       || (hot_q[OH_HWY_WARN]  && short_done)
                       || (hot_q[OH_SIDE_GO]   && leave_side_go)
                       || (hot_q[OH_SIDE_WARN] && short_done);
            end

            // One-hot state register, reset to highway green
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hot_q <= OH_W'(1) << OH_HWY_GO;
                end else begin
                    hot_q <= hot_d;
                end
            end

            // Fold the hot bit back into the shared phase type
            always_comb begin
                unique case (1'b1)
                    hot_q[OH_HWY_WARN]:  phase = PH_HWY_WARN;
                    hot_q[OH_SIDE_GO]:   phase = PH_SIDE_GO;
                    hot_q[OH_SIDE_WARN]: phase = PH_SIDE_WARN;
                    default:             phase = PH_HWY_GO;
                endcase
            end
        end else begin : g_binary
            phase_t cur_q;
            phase_t cur_d;

            // Case-based next-phase and restart decode
            always_comb begin
                cur_d   = cur_q;
                restart = 1'b0;
                unique case (cur_q)
                    PH_HWY_GO: if (leave_hwy_go) begin
                        cur_d   = PH_HWY_WARN;
                        restart = 1'b1;
                    end
                    PH_HWY_WARN: if (short_done) begin
                        cur_d   = PH_SIDE_GO;
                        restart = 1'b1;
                    end
                    PH_SIDE_GO: if (leave_side_go) begin
                        cur_d   = PH_SIDE_WARN;
                        restart = 1'b1;
                    end
                    default: if (short_done) begin
                        cur_d   = PH_HWY_GO;
                        restart = 1'b1;
                    end
                endcase
            end

            // Binary state register, reset to highway green
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cur_q <= PH_HWY_GO;
                end else begin
                    cur_q <= cur_d;
                end
            end

            // Phase is the register itself in this encoding
            always_comb begin
                phase = cur_q;
            end
        end
    endgenerate

endmodule

// File: rtl/xroad_lamp_decode.sv
// Moore output decode: maps the current phase onto the two lamp codes.
// Assumes: the road that is neither green nor amber always shows red.
module xroad_lamp_decode
    import xroad_pkg::*;
(
    input  phase_t phase,
    output lamp_t  hwy_lamp,
    output lamp_t  side_lamp
);
    // Lamp selection per phase
    always_comb begin
        hwy_lamp  = LAMP_STOP;
        side_lamp = LAMP_STOP;
        unique case (phase)
            PH_HWY_GO:    hwy_lamp  = LAMP_GO;
            PH_HWY_WARN:  hwy_lamp  = LAMP_WARN;
            PH_SIDE_GO:   side_lamp = LAMP_GO;
            default:      side_lamp = LAMP_WARN;
        endcase
    end

endmodule

// File: rtl/xroad_light_ctrl.sv
// Intersection light controller top level.
// Joins the interval timer, the phase sequencer and the lamp decode.
// Assumes: car_present is already synchronised and debounced;
// 1 <= SHORT_CYC < LONG_CYC.
module xroad_light_ctrl
    import xroad_pkg::*;
#(
    parameter int SHORT_CYC = 2,
    parameter int LONG_CYC  = 5,
    parameter bit ONE_HOT   = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       car_present,
    output logic [1:0] hwy_light,
    output logic [1:0] side_light
);
    logic   tmr_start;
    logic   short_flag;
    logic   long_flag;
    phase_t cur_phase;
    lamp_t  hwy_lamp;
    lamp_t  side_lamp;

    xroad_interval_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (tmr_start),
        .short_done (short_flag),
        .long_done  (long_flag)
    );

    xroad_phase_fsm #(
        .ONE_HOT (ONE_HOT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .car        (car_present),
        .short_done (short_flag),
        .long_done  (long_flag),
        .phase      (cur_phase),
        .restart    (tmr_start)
    );

    xroad_lamp_decode u_lamps (
        .phase     (cur_phase),
        .hwy_lamp  (hwy_lamp),
        .side_lamp (side_lamp)
    );

    // Drive the plain output ports from the typed lamp codes
    always_comb begin
        hwy_light  = hwy_lamp;
        side_light = side_lamp;
    end

endmodule

// File: rtl/xroad_light_chk.sv
// Property checker for xroad_light_ctrl, attached with bind.
// Tracks green run lengths with counters, so the intervals never appear as
// assertion delays.
module xroad_light_chk #(
    parameter int LONG_CYC = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] hwy,
    input logic [1:0] side,
    input logic       start,
    input logic       long_done
);
    localparam logic [1:0] C_GO   = 2'b00;
    localparam logic [1:0] C_WARN = 2'b01;
    localparam logic [1:0] C_STOP = 2'b10;
    localparam int RUN_W = $clog2(LONG_CYC + 3);
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    logic [RUN_W-1:0] hwy_run_q;
    logic [RUN_W-1:0] side_run_q;
    logic             was_rst_q;

    // Count consecutive green cycles on each road (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hwy_run_q  <= '0;
            side_run_q <= '0;
        end else begin
            hwy_run_q  <= (hwy == C_GO)  ? ((hwy_run_q == RUN_MAX) ? hwy_run_q : hwy_run_q + 1'b1) : '0;
            side_run_q <= (side == C_GO) ? ((side_run_q == RUN_MAX) ? side_run_q : side_run_q + 1'b1) : '0;
        end
    end

    // Remember that the previous edge was a reset edge
    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
        if (rst_n && was_rst_q) begin
            p_reset_hwy_go_r1: assert (hwy == C_GO && side == C_STOP)
                else $error("reset did not leave highway green");
        end
    end

    p_legal_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hwy != 2'b11 && side != 2'b11);

    p_one_road_red_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hwy == C_STOP || side == C_STOP);

    p_hwy_min_green_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy == C_GO) |=> (hwy == C_GO || hwy_run_q >= RUN_W'(LONG_CYC + 1)));

    p_side_max_green_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (side == C_GO) |-> (side_run_q <= RUN_W'(LONG_CYC)));

    p_hwy_warn_not_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy == C_WARN) |=> (hwy != C_GO));

    p_side_warn_not_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (side == C_WARN) |=> (side != C_GO));

    p_restart_clears_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !long_done);

endmodule

bind xroad_light_ctrl xroad_light_chk #(
    .LONG_CYC (LONG_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hwy       (hwy_light),
    .side      (side_light),
    .start     (tmr_start),
    .long_done (long_flag)
);

// File: tb/tb_xroad_light_ctrl.sv
`timescale 1ns/1ps
// Sweeps car arrival and departure cycles over a small timing configuration
// and checks every phase length against closed-form expectations.
module tb_xroad_light_ctrl;
    localparam int SHORT = 2;
    localparam int LONG  = 5;
    localparam logic [1:0] GO = 2'b00, WARN = 2'b01, STOP = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       car = 1'b0;
    logic [1:0] hwy, side, hwy_oh, side_oh;
    int         vectors = 0;
    int         misses = 0;
    bit         cmp_on = 1'b0;

    always #10 clk = ~clk;

    xroad_light_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .ONE_HOT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .car_present(car), .hwy_light(hwy), .side_light(side));

    xroad_light_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .ONE_HOT(1'b1)) dut_oh (
        .clk(clk), .rst_n(rst_n), .car_present(car), .hwy_light(hwy_oh), .side_light(side_oh));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R8: both encodings agree on every cycle
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(hwy == hwy_oh && side == side_oh, "R8 encodings differ",
                {hwy_oh, side_oh}, {hwy, side});
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        car   = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(hwy == GO,   "R1 hwy at reset",  hwy,  GO);
        chk(side == STOP, "R1 side at reset", side, STOP);
        rst_n  = 1'b1;
        cmp_on = 1'b1;
    endtask

    // One full loop: car first high at highway-green cycle a,
    // first low at side-green cycle d
    task automatic run_pair(input int a, input int d);
        int len;
        do_reset();
        len = 0;
        while (hwy == GO && len < 40) begin
            chk(side == STOP, "R2 side red in hwy green", side, STOP);
            car = (len >= a);
            @(negedge clk);
            len++;
        end
        chk(len == ((a > LONG) ? a : LONG) + 1, "R3 hwy green length", len, ((a > LONG) ? a : LONG) + 1);
        chk(hwy == WARN, "R7 hwy green->amber", hwy, WARN);
        len = 0;
        while (hwy == WARN && len < 40) begin
            car = 1'b1;
            @(negedge clk);
            len++;
        end
        chk(len == SHORT + 1, "R4 hwy amber length", len, SHORT + 1);
        chk(hwy == STOP && side == GO, "R4 side green after amber", {hwy, side}, {STOP, GO});
        len = 0;
        while (side == GO && len < 40) begin
            chk(hwy == STOP, "R2 hwy red in side green", hwy, STOP);
            car = (len < d);
            @(negedge clk);
            len++;
        end
        chk(len == ((d < LONG) ? d : LONG) + 1, "R5 side green length", len, ((d < LONG) ? d : LONG) + 1);
        chk(side == WARN, "R7 side green->amber", side, WARN);
        len = 0;
        while (side == WARN && len < 40) begin
            car = 1'b1;
            @(negedge clk);
            len++;
        end
        chk(len == SHORT + 1, "R6 side amber length", len, SHORT + 1);
        chk(hwy == GO && side == STOP, "R6 hwy green after side amber", {hwy, side}, {GO, STOP});
        len = 0;
        while (hwy == GO && len < 40) begin
            car = 1'b1;
            @(negedge clk);
            len++;
        end
        chk(len == LONG + 1, "R3 hwy minimum green with waiting car", len, LONG + 1);
    endtask

    int wd = 0;
    bit done = 1'b0;

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        while (!done && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a <= LONG + 3; a++) begin
            for (int d = 0; d <= LONG + 2; d++) begin
                run_pair(a, d);
            end
        end

        // R9: short early car pulse is ignored
        do_reset();
        car = 1'b0;
        @(negedge clk); car = 1'b1;
        @(negedge clk);
        @(negedge clk); car = 1'b0;
        repeat (LONG + 3) @(negedge clk);
        chk(hwy == GO, "R9 early pulse ignored", hwy, GO);
        car = 1'b1;
        @(negedge clk);
        chk(hwy == WARN, "R9 late car leaves at once", hwy, WARN);

        // R1: reset in mid side-green returns to highway green
        repeat (SHORT + 2) @(negedge clk);
        chk(side == GO, "R1 side green before reset", side, GO);
        rst_n = 1'b0;
        @(negedge clk);
        chk(hwy == GO && side == STOP, "R1 mid-run reset", {hwy, side}, {GO, STOP});
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule